// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces a periodic rectangular waveform on one output pin. A 16-bit up-counter advances on a count-enable strobe taken from a selectable prescaler. A period compare value sets the point at which the counter wraps back to zero. A duty compare value sets a second point inside the cycle. A toggle flip-flop inverts on both matches. The waveform therefore spends (duty + 1) count clocks at its starting level and (period − duty) count clocks at the opposite level.

Software, or a neighbouring block, programs the timer through a small synchronous write port. Address 0 stages the period value, address 1 stages the duty value and address 2 holds the control word. Staged compare values move into the active comparators only when the counter starts or wraps. This keeps a running waveform free of missed or doubled edges. Settings that are not allowed are filtered out in hardware: a reserved level code and a duty value that is not below the period value.

Top module: `ppg_timer`

## Requirements
- R1: While running, the counter advances by one on each count strobe. On the strobe where it equals the active period value P, it returns to zero, so one output cycle spans P+1 count strobes.
- R2: The toggle flip-flop inverts on every count strobe where the counter equals P and on every count strobe where it equals the active duty value D. In steady state the output stays at its start level for D+1 strobes and at the opposite level for P−D strobes.
- R3: Control bits [1:0] select the count strobe rate: 00 gives every system clock, 01 every 4th clock, 10 every 16th clock and 11 every 64th clock.
- R4: Control bit 5 starts the timer when it is set and stops it when it is cleared. On a start (0→1), the counter loads zero and the flip-flop takes the level chosen by control bits [4:3]: 00 sets low, 01 sets high, 10 keeps the level it held while stopped.
- R5: A control write with bits [4:3] equal to 11 is discarded as a whole, and every previous control setting stays in force.
- R6: Writes to address 0 (period) and address 1 (duty) go to staging registers. These become active only at a start or at a counter wrap, and only as a pair whose duty is strictly below its period. Otherwise the active pair is kept.
- R7: The pin is a registered copy of the flip-flop ANDed with the output-enable bit (control bit 2), one system clock late. While the enable bit is clear, the pin stays low.
- R8: After reset the pin is low, the timer is stopped, and the active period and duty values are FFFFh and 7FFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 duty, 2 control |
| wr_data | input | 16 | Write data |
| pulse_out | output | 1 | Registered waveform output |

## Verification
The bench builds the timer with its default 16-bit counter and four-step prescaler. Short period values such as 1, 4, 5 and 9 keep every cycle to a few hundred clocks, so all four strobe rates can be measured phase by phase. Small values also put the duty extremes (D = 0 and D = P − 1) within reach. The bench changes the staged pair while the timer runs to exercise the commit-at-wrap path, the rejection of an illegal pair and the rejection of the reserved level code. It also stops and restarts the timer to check how each start-level code reloads the flip-flop.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] A_DUTY   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  // number of prescaler steps, each step divides by a further 4
  localparam int DIV_STEPS = 4;
  localparam int PRE_W     = 2 * (DIV_STEPS - 1);

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_KEEP = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  // control word: [5] run, [4:3] start level, [2] output enable, [1:0] divide
  typedef struct packed {
    logic       run;
    lvl_e       lvl;
    logic       oe;
    logic [1:0] div;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      per_stg,
  output logic [W-1:0]      duty_stg,
  output ctrl_t             ctrl
);
  ctrl_t wr_ctrl;
  logic  ctrl_ok;

  always_comb begin
    wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
    ctrl_ok = (wr_ctrl.lvl != LVL_RSVD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_stg  <= '1;
      duty_stg <= {1'b0, {(W-1){1'b1}}};
      ctrl     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: per_stg  <= wr_data;
        A_DUTY:   duty_stg <= wr_data;
        A_CTRL:   if (ctrl_ok) ctrl <= wr_ctrl;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ppg_prescale.sv
module ppg_prescale
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < DIV_STEPS; i++) begin
      if (div_sel == 2'(i)) lim = PRE_W'((64'd1 << (2 * i)) - 64'd1);
    end
  end

  assign tick = run && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)     pcnt <= '0;
    else if (pcnt >= lim) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/ppg_core.sv
module ppg_core
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  lvl_e         lvl,
  input  logic [W-1:0] per_stg,
  input  logic [W-1:0] duty_stg,
  output logic         start,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act,
  output logic         ff
);
  logic run_d;
  logic stg_ok;
  logic at_per;
  logic at_duty;

  assign start   = run && !run_d;
  assign stg_ok  = duty_stg < per_stg;
  assign at_per  = (cnt == per_act);
  assign at_duty = (cnt == duty_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d    <= 1'b0;
      cnt      <= '0;
      per_act  <= '1;
      duty_act <= {1'b0, {(W-1){1'b1}}};
      ff       <= 1'b0;
    end else begin
      run_d <= run;
      if (start) begin
        cnt <= '0;
        if (stg_ok) begin
          per_act  <= per_stg;
          duty_act <= duty_stg;
        end
        case (lvl)
          LVL_LOW:  ff <= 1'b0;
          LVL_HIGH: ff <= 1'b1;
          default:  ff <= ff;
        endcase
      end else if (run && tick) begin
        if (at_per) begin
          cnt <= '0;
          if (stg_ok) begin
            per_act  <= per_stg;
            duty_act <= duty_stg;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (at_per || at_duty) ff <= ~ff;
      end
    end
  end
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              pulse_out
);
  ctrl_t        ctrl;
  logic [W-1:0] per_stg, duty_stg;
  logic [W-1:0] cnt, per_act, duty_act;
  logic         tick, start, ff;

  ppg_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_stg(per_stg), .duty_stg(duty_stg), .ctrl(ctrl)
  );

  ppg_prescale u_pre (
    .clk(clk), .rst(rst), .run(ctrl.run), .div_sel(ctrl.div), .tick(tick)
  );

  ppg_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .run(ctrl.run), .tick(tick), .lvl(ctrl.lvl),
    .per_stg(per_stg), .duty_stg(duty_stg), .start(start), .cnt(cnt),
    .per_act(per_act), .duty_act(duty_act), .ff(ff)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_out <= 1'b0;
    else     pulse_out <= ctrl.oe & ff;
  end
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         tick,
  input logic         start,
  input logic         oe,
  input logic [1:0]   lvl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_act,
  input logic [W-1:0] duty_act,
  input logic         pulse_out
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) run |-> cnt <= per_act); // R1
  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (rst) (run && !start && tick && cnt == per_act) |=> cnt == '0); // R1
  AST_PAIR_LEGAL: assert property (@(posedge clk) disable iff (rst) duty_act < per_act); // R6
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst) (!start && !(run && tick && cnt == per_act)) |=> ($stable(per_act) && $stable(duty_act))); // R6
  AST_OUT_OFF: assert property (@(posedge clk) disable iff (rst) !oe |=> !pulse_out); // R7
  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (rst) lvl != 2'b11); // R5
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst) start |=> cnt == '0); // R4
endmodule

bind ppg_timer ppg_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl.run), .tick(tick), .start(start), .oe(ctrl.oe),
  .lvl(ctrl.lvl), .cnt(cnt), .per_act(per_act), .duty_act(duty_act), .pulse_out(pulse_out)
);

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pulse_out;
  int n_chk = 0;
  int n_bad = 0;

  ppg_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pulse_out(pulse_out));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cw(input bit run, input logic [1:0] lvl,
                                     input bit oe, input logic [1:0] dv);
    return {10'd0, run, lvl, oe, dv};
  endfunction

  task automatic cfg(input int p, input int d, input logic [1:0] lvl, input logic [1:0] dv);
    wr(2'd2, cw(0, 2'b00, 0, 2'b00));
    wr(2'd0, 16'(p));
    wr(2'd1, 16'(d));
    wr(2'd2, cw(1, lvl, 1, dv));
  endtask

  // measures one full high phase followed by one full low phase
  task automatic measure(input int exp_hi, input int exp_lo, input string req);
    int hi = 0;
    int lo = 0;
    int g = 0;
    @(negedge clk);
    while (pulse_out !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
    while (pulse_out !== 1'b1 && g < 20000) begin @(negedge clk); g++; end
    while (pulse_out === 1'b1 && g < 20000) begin hi++; @(negedge clk); g++; end
    while (pulse_out === 1'b0 && g < 20000) begin lo++; @(negedge clk); g++; end
    check(hi == exp_hi, {req, " high phase"}, hi, exp_hi);
    check(lo == exp_lo, {req, " low phase"}, lo, exp_lo);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pulse_out === 1'b0, "R8 reset output low", int'(pulse_out), 0);
    repeat (20) @(negedge clk);
    check(pulse_out === 1'b0, "R8 stays low while stopped", int'(pulse_out), 0);
  endtask

  task automatic t_basic();
    cfg(9, 2, 2'b01, 2'b00);
    measure(3, 7, "R1 R2 P9 D2 start high");
    cfg(9, 2, 2'b00, 2'b00);
    measure(7, 3, "R2 P9 D2 start low");
  endtask

  task automatic t_edges();
    cfg(4, 3, 2'b01, 2'b00);
    measure(4, 1, "R2 duty P-1");
    cfg(1, 0, 2'b01, 2'b00);
    measure(1, 1, "R1 P1 D0");
  endtask

  task automatic t_prescale();
    cfg(5, 0, 2'b00, 2'b01);
    measure(20, 4, "R3 divide 4");
    cfg(3, 1, 2'b01, 2'b10);
    measure(32, 32, "R3 divide 16");
    cfg(2, 1, 2'b01, 2'b11);
    measure(128, 64, "R3 divide 64");
  endtask

  task automatic t_oe_off();
    int seen = 0;
    cfg(3, 1, 2'b01, 2'b00);
    wr(2'd2, cw(1, 2'b01, 0, 2'b00));
    repeat (2) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pulse_out !== 1'b0) seen++;
    end
    check(seen == 0, "R7 disabled output stays low", seen, 0);
  endtask

  task automatic t_rsvd_level();
    cfg(9, 2, 2'b01, 2'b00);
    wr(2'd2, 16'b0000_0000_0001_1000); // run=0, level 11, oe=0
    measure(3, 7, "R5 reserved level write ignored");
  endtask

  task automatic t_shadow();
    cfg(9, 2, 2'b01, 2'b00);
    wr(2'd1, 16'd9); // duty == period: pair is illegal
    repeat (40) @(negedge clk);
    measure(3, 7, "R6 illegal pair kept out");
    wr(2'd0, 16'd19);
    wr(2'd1, 16'd4);
    repeat (60) @(negedge clk);
    measure(5, 15, "R6 staged pair applied at wrap");
  endtask

  task automatic t_start_level();
    cfg(100, 50, 2'b01, 2'b00);
    repeat (10) @(negedge clk);
    wr(2'd2, cw(0, 2'b01, 1, 2'b00));
    wr(2'd2, cw(1, 2'b10, 1, 2'b00));
    repeat (2) @(negedge clk);
    check(pulse_out === 1'b1, "R4 keep level on restart", int'(pulse_out), 1);
    wr(2'd2, cw(0, 2'b10, 1, 2'b00));
    wr(2'd2, cw(1, 2'b00, 1, 2'b00));
    repeat (2) @(negedge clk);
    check(pulse_out === 1'b0, "R4 low level on restart", int'(pulse_out), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_edges();
        t_prescale();
        t_oe_off();
        t_rsvd_level();
        t_shadow();
        t_start_level();
      end
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule